// File: doc/BRIEF.md
# Banked 16-bit Memory Subsystem

This block sits on the demultiplexed address and control bus of a 16-bit processor that has a 20-bit address space. It turns the raw read, write and memory/IO strobes into four decoded strobes. It also holds two 16KB regions. The first is a read/write region built from an even byte bank and an odd byte bank. The second is a read-only region whose image is computed by a package function. Both regions answer on a 16-bit data path. The even bank drives the low byte lane and the odd bank drives the high byte lane.

Region selection uses only address bit 19, so each region repeats across its half of the space. The byte-high enable and address bit 0 together choose which lanes of the read/write region take part in a write or return data on a read. The read-only region always returns both lanes, because a read cannot corrupt anything. A small bus-cycle state machine tracks the current cycle type. It has four states:

- `ST_IDLE`: no cycle is active.
- `ST_MEM_RD`: a memory read is in progress.
- `ST_MEM_WR`: a memory write is in progress.
- `ST_IO`: an IO cycle is in progress.

On every clock the machine moves to the state that matches the decoded strobes. A memory read takes priority, then a memory write, then an IO read or write. With no strobe active it returns to `ST_IDLE`. The transition into `ST_MEM_WR` commits exactly one write. Read data is registered and is flagged valid while the machine is in `ST_MEM_RD`.

Top module: `msys_banked_mem`

## Requirements
- R1: The strobe outputs decode combinationally:
  - `mem_rd` = rd_n low and m_io high.
  - `mem_wr` = wr_n low and m_io high.
  - `io_rd` = rd_n low and m_io low.
  - `io_wr` = wr_n low and m_io low.
- R2: Address bit 19 alone picks the region: 0 selects read/write storage and 1 selects read-only storage. For example, 40120h reaches the read/write region and 81710h reaches the read-only region.
- R3: Inside a bank the location is address bits 13..1. Read/write addresses therefore alias modulo 16KB: 04120h and 08122h reach the same words as 00120h and 00122h.
- R4: The even bank is data bits 7..0 and the odd bank is data bits 15..8. A word write of 3B7Ch to 00120h reads back as 3B7Ch.
- R5: Read/write lane enables follow {bhe_n, A0}. 00 enables both lanes, 01 enables the odd lane only, and 10 enables the even lane only. A byte write leaves the other byte unchanged. On a read, a disabled lane returns 00h.
- R6: With {bhe_n, A0} = 11, no read/write lane is enabled. A write then changes nothing.
- R7: Read-only bytes at even image offsets sit in the even bank and bytes at odd offsets sit in the odd bank. Both lanes are returned on every read, whatever bhe_n and A0 are. Offsets 1710h..1713h hold AC, 7D, 36 and EB. Reads at FD710h and FD711h therefore return 7DACh, and a read at FD712h returns EB36h.
- R8: A write into the read-only region has no effect.
- R9: `rdata_vld` rises one clock after `mem_rd` is first sampled high. It stays high with stable data while the strobe is held, and it falls one clock after release. `rdata` is 0000h whenever `rdata_vld` is low. IO cycles never raise `rdata_vld`.
- R10: Each assertion of the memory write strobe commits exactly once, on the first clock edge that samples it. Data that changes while the strobe is still held is not stored.
- R11: After reset the state is `ST_IDLE`, `rdata_vld` is low and `rdata` is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Latched address |
| bhe_n | input | 1 | Active-low high-byte enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| m_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| wdata | input | 16 | Write data from processor |
| mem_rd | output | 1 | Decoded memory read |
| mem_wr | output | 1 | Decoded memory write |
| io_rd | output | 1 | Decoded IO read |
| io_wr | output | 1 | Decoded IO write |
| rdata | output | 16 | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
The decoded strobes are combinational, so the bench checks them a short delay after it drives the control inputs, within the same cycle. Read data and `rdata_vld` pass through one register. The bench drives every input on a falling edge. The monitor looks for `rdata_vld` rising on the next falling edge and compares `rdata` against the oldest entry in the scoreboard queue at that point. A write commits on the rising edge after the strobe is driven. Every read that checks a write is therefore issued at least one full cycle after the write strobe is released.

// File: rtl/msys_pkg.sv
package msys_pkg;

    localparam int MS_ADDR_W     = 20;
    localparam int MS_DATA_W     = 16;
    localparam int MS_BYTE_W     = 8;
    localparam int MS_BANK_AW    = 13;
    localparam int MS_REGION_BIT = 19;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEM_RD = 2'd1,
        ST_MEM_WR = 2'd2,
        ST_IO     = 2'd3
    } bus_state_e;

    // Read-only image: a few fixed bytes, the rest derived from the offset
    function automatic logic [7:0] rom_image_byte(input logic [31:0] off);
        logic [13:0] o;
        o = off[13:0];
        unique case (o)
            14'h1710: rom_image_byte = 8'hAC;
            14'h1711: rom_image_byte = 8'h7D;
            14'h1712: rom_image_byte = 8'h36;
            14'h1713: rom_image_byte = 8'hEB;
            default:  rom_image_byte = o[7:0] ^ {2'b00, o[13:8]} ^ 8'h5A;
        endcase
    endfunction

endpackage

// File: rtl/msys_strobe_dec.sv
module msys_strobe_dec (
    input  logic rd_n,
    input  logic wr_n,
    input  logic m_io,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_rd,
    output logic io_wr
);
    always_comb begin
        mem_rd = !rd_n &&  m_io;
        mem_wr = !wr_n &&  m_io;
        io_rd  = !rd_n && !m_io;
        io_wr  = !wr_n && !m_io;
    end
endmodule

// File: rtl/msys_lane_sel.sv
module msys_lane_sel (
    input  logic       is_rom,
    input  logic       bhe_n,
    input  logic       a0,
    output logic [1:0] lane_en   // bit0 even lane, bit1 odd lane
);
    always_comb begin
        if (is_rom) begin
            lane_en = 2'b11;
        end else begin
            unique case ({bhe_n, a0})
                2'b00:   lane_en = 2'b11;
                2'b01:   lane_en = 2'b10;
                2'b10:   lane_en = 2'b01;
                default: lane_en = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/msys_ram_bank.sv
module msys_ram_bank #(
    parameter int AW = 13,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [BW-1:0] wd,
    output logic [BW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [BW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= wd;
        end
    end

    assign rd = store[idx];
endmodule

// File: rtl/msys_rom_bank.sv
module msys_rom_bank #(
    parameter int AW   = 13,
    parameter int BW   = 8,
    parameter int LANE = 0
) (
    input  logic [AW-1:0] idx,
    output logic [BW-1:0] q
);
    import msys_pkg::*;

    logic [7:0] img;

    always_comb begin
        img = rom_image_byte(32'({idx, 1'(LANE)}));
        q   = BW'(img);
    end
endmodule

// File: rtl/msys_banked_mem.sv
module msys_banked_mem
    import msys_pkg::*;
#(
    parameter int ADDR_W     = MS_ADDR_W,
    parameter int DATA_W     = MS_DATA_W,
    parameter int BANK_AW    = MS_BANK_AW,
    parameter int REGION_BIT = MS_REGION_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m_io,
    input  logic [DATA_W-1:0] wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    bus_state_e state_q, state_d;

    logic                 is_rom;
    logic [1:0]           lane_en;
    logic [BANK_AW-1:0]   bank_idx;
    logic                 wr_commit;
    logic [LANES-1:0]     ram_we;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    rdata_q;
    logic                 vld_q;

    assign is_rom   = addr[REGION_BIT];
    assign bank_idx = addr[BANK_AW:1];

    msys_strobe_dec u_dec (
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .m_io   (m_io),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .io_rd  (io_rd),
        .io_wr  (io_wr)
    );

    msys_lane_sel u_lane (
        .is_rom  (is_rom),
        .bhe_n   (bhe_n),
        .a0      (addr[0]),
        .lane_en (lane_en)
    );

    // Next-state selection: read outranks write, write outranks IO
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_MEM_RD, ST_MEM_WR, ST_IO: begin
                if (mem_rd)              state_d = ST_MEM_RD;
                else if (mem_wr)         state_d = ST_MEM_WR;
                else if (io_rd || io_wr) state_d = ST_IO;
                else                     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // One commit on entry to the write state, read/write region only
    assign wr_commit = (state_d == ST_MEM_WR) && (state_q != ST_MEM_WR) && !is_rom;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] ram_q;
        logic [LANE_W-1:0] rom_q;

        assign ram_we[g] = wr_commit && lane_en[g];

        msys_ram_bank #(.AW(BANK_AW), .BW(LANE_W)) u_ram (
            .clk (clk),
            .we  (ram_we[g]),
            .idx (bank_idx),
            .wd  (wdata[g*LANE_W +: LANE_W]),
            .rd  (ram_q)
        );

        msys_rom_bank #(.AW(BANK_AW), .BW(LANE_W), .LANE(g)) u_rom (
            .idx (bank_idx),
            .q   (rom_q)
        );

        assign rd_word[g*LANE_W +: LANE_W] =
            !lane_en[g] ? '0 : (is_rom ? rom_q : ram_q);
    end

    // Output process: registered read data, valid while reading
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            unique case (state_d)
                ST_MEM_RD: begin
                    rdata_q <= rd_word;
                    vld_q   <= 1'b1;
                end
                ST_IDLE, ST_MEM_WR, ST_IO: begin
                    rdata_q <= '0;
                    vld_q   <= 1'b0;
                end
                default: begin
                    rdata_q <= '0;
                    vld_q   <= 1'b0;
                end
            endcase
        end
    end

    assign rdata     = rdata_q;
    assign rdata_vld = vld_q;

    // R9: valid follows the memory read strobe by one clock
    a_r9_vld_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> rdata_vld);

    // R9: valid drops after the strobe is released
    a_r9_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> !rdata_vld);

    // R9: IO cycles never flag read data
    a_r9_no_vld_io: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && !mem_rd |=> !rdata_vld);

    // R10: never two commits on back-to-back edges
    a_r10_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R8: read-only region never receives a bank write
    a_r8_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        addr[REGION_BIT] |-> (ram_we == '0));

    // R6: both enables high keep every bank untouched
    a_r6_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr[REGION_BIT] && bhe_n && addr[0]) |-> (ram_we == '0));

    // R7: read-only reads always engage both lanes
    a_r7_rom_both: assert property (@(posedge clk) disable iff (!rst_n)
        addr[REGION_BIT] |-> (lane_en == 2'b11));

    // R11: data is zero whenever not valid
    a_r11_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0));

endmodule

// File: tb/msys_banked_mem_tb.sv
module msys_banked_mem_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        m_io = 1'b1;
    logic [15:0] wdata = '0;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [15:0] rdata;
    logic        rdata_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    msys_banked_mem dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .bhe_n     (bhe_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .m_io      (m_io),
        .wdata     (wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: on each rising valid, pop and compare
    logic vld_prev = 1'b0;
    always @(negedge clk) begin
        if (rdata_vld && !vld_prev) begin
            if (sb_q.size() == 0) begin
                chk(32'(rdata), 32'hDEAD, "scoreboard empty on valid");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(32'(rdata), 32'(it.exp), it.tag);
            end
        end
        vld_prev = rdata_vld;
    end

    task automatic do_write(input logic [19:0] a, input logic bh, input logic [15:0] d);
        @(negedge clk);
        addr = a; bhe_n = bh; wdata = d; m_io = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [19:0] a, input logic bh,
                           input logic [15:0] e, input string tag);
        sb_q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        addr = a; bhe_n = bh; m_io = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe_chk(input logic r, input logic w, input logic m,
                              input logic [3:0] exp);
        rd_n = r; wr_n = w; m_io = m;
        #1;
        chk(32'({mem_rd, mem_wr, io_rd, io_wr}), 32'(exp), "R1 strobe decode");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(32'(rdata_vld), 32'h0, "R11 valid in reset");
        chk(32'(rdata), 32'h0, "R11 data in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(rdata_vld), 32'h0, "R11 valid after reset");

        // R1 strobe decode: {mem_rd, mem_wr, io_rd, io_wr}
        @(negedge clk);
        strobe_chk(1'b0, 1'b1, 1'b1, 4'b1000);
        strobe_chk(1'b1, 1'b0, 1'b1, 4'b0100);
        strobe_chk(1'b0, 1'b1, 1'b0, 4'b0010);
        strobe_chk(1'b1, 1'b0, 1'b0, 4'b0001);
        strobe_chk(1'b1, 1'b1, 1'b1, 4'b0000);
        rd_n = 1'b1; wr_n = 1'b1; m_io = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // R4 word write and read back
        do_write(20'h00120, 1'b0, 16'h3B7C);
        do_read (20'h00120, 1'b0, 16'h3B7C, "R4 word readback");
        // R3 aliasing modulo 16KB
        do_read (20'h04120, 1'b0, 16'h3B7C, "R3 alias read 04120");
        do_write(20'h08122, 1'b0, 16'h1234);
        do_read (20'h00122, 1'b0, 16'h1234, "R3 alias write 08122");
        // R2 bit 19 low selects read/write region
        do_read (20'h40120, 1'b0, 16'h3B7C, "R2 bit19 low is RAM");

        // R5 byte writes
        do_write(20'h00121, 1'b0, 16'hAA55);
        do_read (20'h00120, 1'b0, 16'hAA7C, "R5 odd byte write");
        do_write(20'h00120, 1'b1, 16'h1111);
        do_read (20'h00120, 1'b0, 16'hAA11, "R5 even byte write");
        do_read (20'h00120, 1'b1, 16'h0011, "R5 even-only read lane");
        do_read (20'h00121, 1'b0, 16'hAA00, "R5 odd-only read lane");

        // R6 no lane enabled
        do_write(20'h00121, 1'b1, 16'hFFFF);
        do_read (20'h00120, 1'b0, 16'hAA11, "R6 no-lane write ignored");

        // R7 read-only image
        do_read (20'hFD710, 1'b0, 16'h7DAC, "R7 rom word FD710");
        do_read (20'hFD712, 1'b0, 16'hEB36, "R7 rom word FD712");
        do_read (20'hFD711, 1'b1, 16'h7DAC, "R7 rom both lanes");
        // R2 bit 19 high selects read-only region
        do_read (20'h81710, 1'b0, 16'h7DAC, "R2 bit19 high is ROM");

        // R8 write to read-only region ignored
        do_write(20'hFD710, 1'b0, 16'h0000);
        do_read (20'hFD710, 1'b0, 16'h7DAC, "R8 rom write ignored");
        do_read (20'h00120, 1'b0, 16'hAA11, "R8 RAM alias untouched");

        // R10 single commit per held strobe
        @(negedge clk);
        addr = 20'h00200; bhe_n = 1'b0; wdata = 16'h5555; wr_n = 1'b0; m_io = 1'b1;
        @(negedge clk);
        wdata = 16'h6666;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        do_read (20'h00200, 1'b0, 16'h5555, "R10 held write commits once");

        // R9 held read keeps valid and data
        sb_q.push_back('{exp: 16'h3B7C ^ 16'h0000 ^ 16'h916D, tag: "R9 held read first"});
        @(negedge clk);
        addr = 20'h00120; bhe_n = 1'b0; rd_n = 1'b0; m_io = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(32'(rdata_vld), 32'h1, "R9 valid held");
        chk(32'(rdata), 32'hAA11, "R9 data held");
        rd_n = 1'b1;
        @(negedge clk);
        chk(32'(rdata_vld), 32'h0, "R9 valid falls");
        chk(32'(rdata), 32'h0, "R9 data zero after");

        // R9 IO read never valid
        @(negedge clk);
        addr = 20'h00120; rd_n = 1'b0; m_io = 1'b0;
        @(negedge clk);
        chk(32'(rdata_vld), 32'h0, "R9 IO read no valid");
        @(negedge clk);
        chk(32'(rdata), 32'h0, "R9 IO read data zero");
        rd_n = 1'b1; m_io = 1'b1;
        @(negedge clk);
        @(negedge clk);

        chk(32'(sb_q.size()), 32'h0, "scoreboard drained");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule